// File: doc/BRIEF.md
# Buffered Edge-Aligned PWM Channel

This block produces an edge-aligned pulse-width-modulated output from an internal up-counter. The counter steps from 1 up to the active period value and then starts again at 1. Each return to 1 is a period boundary. The output sits at the inverse of the polarity level from the boundary until the counter reaches the active duty value, and then drops to the polarity level for the rest of the period. Over a period of P steps with a duty value D, the inverse level therefore lasts for min(D, P) steps.

Software programs the channel through a simple write port. It writes staged duty and period values, and those values become active only at a period boundary, so a new setting never cuts a period short. When the period match and the duty match land in the same step, the period match wins. This gives exact 0% and 100% outputs without any special-case register. An optional prescaler mode makes the counter advance only on clocks that carry an external tick. A one-clock pulse and a sticky flag mark each period boundary.

Top module: `pwm_edge_chan`

## Requirements
- R1: While reset is asserted, `pwmOut` is 1 (the inverse of the reset polarity 0), and `periodPulse` and `periodFlag` are 0. The reset active values are duty 0 and period 1, and the staged values reset to the same.
- R2: Register map on `wrAddr`: 0 is the staged duty value, 1 is the staged period value, 2 is control (bit 0 is polarity, bit 1 is prescaler enable), and 3 clears the flag (write 1 to bit 0). With an active duty D where 1 <= D < P, `pwmOut` holds the inverse of polarity for D steps and then holds polarity for P-D steps.
- R3: If the active duty is greater than or equal to the active period, `pwmOut` stays at the inverse of polarity for the whole period. When the duty match and the period match fall on the same step, the period match decides the level.
- R4: An active duty of 0 keeps `pwmOut` at the polarity level at all times. The boundary step applies the new duty of 0 at once, so no step at the inverse level appears.
- R5: The counter runs 1, 2, ..., P and then returns to 1, so one period lasts P steps. A period value of 0 behaves as 1.
- R6: Staged duty and period values move into the active registers together, and only at a period boundary. A staged write made on the same clock as a boundary takes effect at the next boundary.
- R7: `periodPulse` is high for one clock after each boundary step. `periodFlag` sets at the same time and stays set until a write of 1 to bit 0 at address 3. If a set and a clear fall on the same clock, the set wins.
- R8: With the prescaler enable at 0, the counter steps on every clock. With it at 1, the counter steps only on clocks where `tick` is 1. On other clocks the output, the pulse and the counter do not change.
- R9: A write to the polarity bit inverts the level of `pwmOut` from the next clock onward, in both phases of the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address |
| wrData | input | CNT_W | Write data |
| tick | input | 1 | Prescaler step qualifier |
| pwmOut | output | 1 | PWM output |
| periodPulse | output | 1 | One-clock pulse after each period boundary |
| periodFlag | output | 1 | Sticky period flag |

## Verification
The period match and the duty match can fall on the same step. The bench provokes this with a duty equal to the period, with a duty above the period, and with a period of 1, where every step is a boundary. It judges the result by the inverse-level sample count across a whole period, which must equal the full period. The flag set and the flag clear are the second same-cycle pair. The bench forces them together by issuing a tick and a clear write on one clock while the period is 1, and then requires that the flag is still set.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_DUTY = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PER  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CLR  = 2'd3;

  localparam int CTRL_POL_BIT = 0;
  localparam int CTRL_PRE_BIT = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic step;   // counter advances this clock
    logic wrap;   // this step ends the period
  } pwmStrobes_t;

endpackage

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [CNT_W-1:0]    wrData,
  input  pwmStrobes_t         strobes,
  output logic                cntEqDuty,
  output logic                cntAtPeriod,
  output logic                dutyStageZero,
  output logic                polarity,
  output logic                prescaleEn,
  output logic                flagClr,
  output logic [CNT_W-1:0]    activeDuty,
  output logic [CNT_W-1:0]    activePeriod
);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dutyStage;
  logic [CNT_W-1:0] perStage;
  logic [CNT_W-1:0] dutyAct;
  logic [CNT_W-1:0] perAct;

  // staging and control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyStage  <= CNT_ZERO;
      perStage   <= CNT_ONE;
      polarity   <= 1'b0;
      prescaleEn <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_DUTY: dutyStage <= wrData;
        ADDR_PER:  perStage  <= wrData;
        ADDR_CTRL: begin
          polarity   <= wrData[CTRL_POL_BIT];
          prescaleEn <= wrData[CTRL_PRE_BIT];
        end
        default: ;
      endcase
    end
  end

  // counter and active compare registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= CNT_ONE;
      dutyAct <= CNT_ZERO;
      perAct  <= CNT_ONE;
    end else if (strobes.step) begin
      if (strobes.wrap) begin
        cnt     <= CNT_ONE;
        dutyAct <= dutyStage;
        perAct  <= perStage;
      end else begin
        cnt <= cnt + CNT_ONE;
      end
    end
  end

  assign cntEqDuty     = (cnt == dutyAct);
  assign cntAtPeriod   = (cnt >= perAct);
  assign dutyStageZero = (dutyStage == CNT_ZERO);
  assign flagClr       = wrEn && (wrAddr == ADDR_CLR) && wrData[0];
  assign activeDuty    = dutyAct;
  assign activePeriod  = perAct;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (cnt >= CNT_ONE) && ((cnt <= perAct) || (cnt == CNT_ONE))); // R5

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.step |=> $stable(cnt)); // R8

  AST_BUF_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.step && strobes.wrap) |=> ($stable(dutyAct) && $stable(perAct))); // R6

endmodule

// File: rtl/pwm_control.sv
module pwm_control
  import pwm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        prescaleEn,
  input  logic        cntEqDuty,
  input  logic        cntAtPeriod,
  input  logic        dutyStageZero,
  input  logic        flagClr,
  output pwmStrobes_t strobes,
  output logic        phaseInv,
  output logic        periodPulse,
  output logic        periodFlag
);

  always_comb begin
    strobes.step = !prescaleEn || tick;
    strobes.wrap = strobes.step && cntAtPeriod;
  end

  // output phase: 1 = inverse of polarity, 0 = polarity level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseInv <= 1'b1;
    end else if (strobes.wrap) begin
      // period match wins; a zero staged duty matches on this same step
      phaseInv <= !dutyStageZero;
    end else if (strobes.step && cntEqDuty) begin
      phaseInv <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodPulse <= 1'b0;
      periodFlag  <= 1'b0;
    end else begin
      periodPulse <= strobes.wrap;
      if (strobes.wrap)  periodFlag <= 1'b1;
      else if (flagClr)  periodFlag <= 1'b0;
    end
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    periodPulse |-> periodFlag); // R7

  AST_PULSE_ON_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.step |=> !periodPulse); // R8

endmodule

// File: rtl/pwm_edge_chan.sv
module pwm_edge_chan
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              tick,
  output logic              pwmOut,
  output logic              periodPulse,
  output logic              periodFlag
);

  pwmStrobes_t      strobes;
  logic             cntEqDuty;
  logic             cntAtPeriod;
  logic             dutyStageZero;
  logic             polarity;
  logic             prescaleEn;
  logic             flagClr;
  logic             phaseInv;
  logic [CNT_W-1:0] activeDuty;
  logic [CNT_W-1:0] activePeriod;

  pwm_datapath #(.CNT_W(CNT_W)) i_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .wrEn          (wrEn),
    .wrAddr        (wrAddr),
    .wrData        (wrData),
    .strobes       (strobes),
    .cntEqDuty     (cntEqDuty),
    .cntAtPeriod   (cntAtPeriod),
    .dutyStageZero (dutyStageZero),
    .polarity      (polarity),
    .prescaleEn    (prescaleEn),
    .flagClr       (flagClr),
    .activeDuty    (activeDuty),
    .activePeriod  (activePeriod)
  );

  pwm_control i_control (
    .clk           (clk),
    .rstN          (rstN),
    .tick          (tick),
    .prescaleEn    (prescaleEn),
    .cntEqDuty     (cntEqDuty),
    .cntAtPeriod   (cntAtPeriod),
    .dutyStageZero (dutyStageZero),
    .flagClr       (flagClr),
    .strobes       (strobes),
    .phaseInv      (phaseInv),
    .periodPulse   (periodPulse),
    .periodFlag    (periodFlag)
  );

  assign pwmOut = phaseInv ? !polarity : polarity;

  AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rstN)
    ((activeDuty >= activePeriod) && (activeDuty != '0)) |-> phaseInv); // R3

endmodule

// File: tb/test_pwm_edge_chan.sv
`timescale 1ns/1ps
module test_pwm_edge_chan;

  localparam int CNT_W = 16;

  typedef struct packed {
    logic pol;
    logic pre;
    int   duty;
    int   per;
    int   expPer;
    int   expAct;
  } vec_t;

  // expPer/expAct in clocks; prescaled vectors use a tick every 3rd clock
  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0,  3, 8,  8, 3},   // R2 mid duty
    '{1'b0, 1'b0,  8, 8,  8, 8},   // R3 duty == period
    '{1'b0, 1'b0,  0, 8,  8, 0},   // R4 zero duty
    '{1'b1, 1'b0,  2, 5,  5, 2},   // R9 inverted polarity
    '{1'b0, 1'b0, 12, 6,  6, 6},   // R3 duty above period
    '{1'b0, 1'b1,  2, 4, 12, 6},   // R8 prescaled
    '{1'b1, 1'b0,  1, 1,  1, 1},   // R3 period 1
    '{1'b0, 1'b0,  5, 0,  1, 1},   // R5 period 0 acts as 1
    '{1'b0, 1'b0,  1, 2,  2, 1}    // R2 minimum duty
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [1:0]       wrAddr = '0;
  logic [CNT_W-1:0] wrData = '0;
  logic             tick = 1'b0;
  logic             pwmOut;
  logic             periodPulse;
  logic             periodFlag;

  int checks = 0;
  int fails = 0;
  int tickRate = 1;
  int tickCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_edge_chan #(.CNT_W(CNT_W)) i_pwm_edge_chan (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .tick        (tick),
    .pwmOut      (pwmOut),
    .periodPulse (periodPulse),
    .periodFlag  (periodFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: sample point at negedge, then default inputs for next edge
  task automatic cyc();
    @(negedge clk);
    wrEn = 1'b0;
    tickCnt++;
    tick = (tickRate != 0) && ((tickCnt % ((tickRate == 0) ? 1 : tickRate)) == 0);
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    cyc();
    wrEn = 1'b1;
    wrAddr = a;
    wrData = CNT_W'(d);
  endtask

  task automatic waitPulse();
    cyc();
    for (int i = 0; i < 2000 && !periodPulse; i++) cyc();
  endtask

  task automatic measure(output int per, output int act, input logic pol);
    per = 1;
    act = (pwmOut != pol) ? 1 : 0;
    for (int i = 0; i < 2000; i++) begin
      cyc();
      if (periodPulse) break;
      per++;
      if (pwmOut != pol) act++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R5 watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int per;
    int act;
    logic lastOut;
    int seen;

    // reset state (R1)
    repeat (3) @(negedge clk);
    check("R1 pwmOut", int'(pwmOut), 1);
    check("R1 periodPulse", int'(periodPulse), 0);
    check("R1 periodFlag", int'(periodFlag), 0);
    rstN = 1'b1;

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      tickRate = VECS[v].pre ? 3 : 1;
      wr(2'd2, {30'd0, VECS[v].pre, VECS[v].pol});
      wr(2'd0, VECS[v].duty);
      wr(2'd1, VECS[v].per);
      waitPulse();
      waitPulse();
      measure(per, act, VECS[v].pol);
      check($sformatf("R5 period vec%0d", v), per, VECS[v].expPer);
      check($sformatf("R2 R3 R4 active vec%0d", v), act, VECS[v].expAct);
    end

    // period 1, zero duty, every clock a boundary
    tickRate = 1;
    wr(2'd2, 0);
    wr(2'd0, 0);
    wr(2'd1, 1);
    repeat (4) cyc();
    check("R4 zero duty level", int'(pwmOut), 0);
    check("R7 flag set", int'(periodFlag), 1);

    // prescaler on, no ticks: everything holds (R8)
    tickRate = 0;
    wr(2'd2, 2);
    cyc();
    wr(2'd3, 1);
    cyc();
    check("R7 flag cleared", int'(periodFlag), 0);
    lastOut = pwmOut;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      cyc();
      if (periodPulse || pwmOut != lastOut) seen++;
    end
    check("R8 no activity without tick", seen, 0);

    // set and clear on the same clock: set wins (R7)
    cyc();
    wrEn = 1'b1; wrAddr = 2'd3; wrData = 1; tick = 1'b1;
    cyc();
    check("R7 set beats clear flag", int'(periodFlag), 1);
    check("R7 pulse", int'(periodPulse), 1);
    cyc();
    check("R7 pulse single clock", int'(periodPulse), 0);

    // staged write on the boundary clock waits a period (R6)
    cyc();
    wrEn = 1'b1; wrAddr = 2'd0; wrData = 5; tick = 1'b1;
    cyc();
    check("R6 old duty used at boundary", int'(pwmOut), 0);
    tick = 1'b1;
    cyc();
    check("R6 R3 new duty after next boundary", int'(pwmOut), 1);

    // staged values inert until the boundary (R6)
    wr(2'd1, 6);
    wr(2'd0, 3);
    cyc();
    check("R6 staged no effect", int'(pwmOut), 1);
    for (int t = 1; t <= 4; t++) begin
      tick = 1'b1;
      cyc();
      if (t == 3) check("R6 R2 level after 3 steps", int'(pwmOut), 1);
      if (t == 4) check("R2 level after duty match", int'(pwmOut), 0);
    end
    check("R5 no pulse mid period", int'(periodPulse), 0);

    // polarity flip (R9)
    wr(2'd2, 3);
    cyc();
    check("R9 polarity inverts output", int'(pwmOut), 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule